// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds a set of display configuration words in two layers. Software may rewrite the staging layer at any point in a frame. The live layer feeds the pixel pipeline and changes only when a vertical update strobe arrives. On that strobe every live word is reloaded from its staging word in the same clock edge, so the pipeline never sees a half-applied set of values. Between two strobes the staging layer behaves like a mailbox: if a word is rewritten several times, only the last value written is applied.

A lock input lets software perform a change that spans several words without racing the strobe. While the lock is high, strobes are ignored. The next strobe that arrives with the lock low applies the whole set. A status flag reports that staged values exist that have not yet reached the live layer. The write port has no handshake. It accepts one word on every cycle in which its enable is high and never applies back-pressure.

Top module: `dbuf_cfg_bank`

## Requirements
- R1: After reset, live word i equals RST_SEED XOR i (with the defaults, 0xA5A50000 XOR i), the staging words hold the same values, and pend_flag is 0.
- R2: A write changes only the staging word it addresses. Live outputs stay unchanged on every cycle that has no unlocked strobe.
- R3: A strobe with lock low copies every staging word into its live word. The copy is visible on the outputs in the cycle after the strobe edge.
- R4: When a word is written several times between two unlocked strobes, the value applied is the last one written.
- R5: A strobe with lock high leaves the live words unchanged. The staged values are applied at the next strobe that arrives with lock low.
- R6: pend_flag is 1 in the cycle after any accepted write.
- R7: pend_flag returns to 0 after an unlocked strobe that has no write in the same cycle. It stays 1 across locked strobes.
- R8: A write in the same cycle as an unlocked strobe is not applied by that strobe. The strobe applies the value staged before the write, the new value waits for the next unlocked strobe, and pend_flag stays 1.
- R9: Words that were never written keep their reset values through any number of commits. Live word i occupies bits [i*DATA_W +: DATA_W] of act_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable for the staging layer |
| wr_addr | input | ADDR_W | Index of the word to write |
| wr_data | input | DATA_W | Value to stage |
| upd_strobe | input | 1 | Vertical update event, one cycle |
| upd_lock | input | 1 | When high, strobes are ignored |
| act_cfg | output | NUM_REGS*DATA_W | Live words, word i at bits [i*DATA_W +: DATA_W] |
| pend_flag | output | 1 | High while staged values have not yet been applied |

## Verification
The hardest case to reach is a write landing in exactly the same cycle as an unlocked strobe. In that cycle the strobe must apply the older staged value while the new value stays pending. The bench drives wr_en and upd_strobe together in one cycle. It then checks that the live word holds the earlier value, that pend_flag is still set, and that a second strobe applies the newer value. Lock deferral is reached by interleaving several locked strobes with writes before the lock is released.

// File: rtl/dbuf_cfg_pkg.sv
package dbuf_cfg_pkg;
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dbuf_stage_bank.sv
module dbuf_stage_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter logic [DATA_W-1:0] RST_SEED = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_REGS*DATA_W-1:0]   stage_q
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)
        stage_q[i*DATA_W +: DATA_W] <= RST_SEED ^ DATA_W'(i);
      else if (hit)
        stage_q[i*DATA_W +: DATA_W] <= wr_data;
    end
  end
endmodule

// File: rtl/dbuf_live_bank.sv
module dbuf_live_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] RST_SEED = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_REGS*DATA_W-1:0]  stage_q,
  output logic [NUM_REGS*DATA_W-1:0]  live_q
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        live_q[i*DATA_W +: DATA_W] <= RST_SEED ^ DATA_W'(i);
      else if (load)
        live_q[i*DATA_W +: DATA_W] <= stage_q[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/dbuf_commit_ctrl.sv
module dbuf_commit_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic upd_strobe,
  input  logic upd_lock,
  output logic commit,
  output logic pend_q
);
  assign commit = upd_strobe && !upd_lock;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (wr_en)
      pend_q <= 1'b1;
    else if (commit)
      pend_q <= 1'b0;
  end
endmodule

// File: rtl/dbuf_cfg_bank.sv
module dbuf_cfg_bank
  import dbuf_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] RST_SEED = 32'hA5A5_0000,
  localparam int unsigned ADDR_W  = idx_bits(NUM_REGS),
  localparam int unsigned FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd_strobe,
  input  logic              upd_lock,
  output logic [FLAT_W-1:0] act_cfg,
  output logic              pend_flag
);
  logic [FLAT_W-1:0] stage_q;
  logic              commit;

  dbuf_stage_bank #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RST_SEED(RST_SEED)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stage_q(stage_q)
  );

  dbuf_commit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .upd_strobe(upd_strobe),
    .upd_lock(upd_lock), .commit(commit), .pend_q(pend_flag)
  );

  dbuf_live_bank #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RST_SEED(RST_SEED)
  ) u_live (
    .clk(clk), .rst_n(rst_n), .load(commit), .stage_q(stage_q), .live_q(act_cfg)
  );
endmodule

// File: rtl/dbuf_cfg_bank_chk.sv
module dbuf_cfg_bank_chk #(
  parameter int unsigned FLAT_W = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              upd_strobe,
  input logic              upd_lock,
  input logic [FLAT_W-1:0] stage_q,
  input logic [FLAT_W-1:0] act_cfg,
  input logic              pend_flag
);
  // R2: no unlocked strobe, live words hold
  a_r2_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_strobe && !upd_lock) |=> $stable(act_cfg));
  // R3: unlocked strobe copies the staging layer
  a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && !upd_lock) |=> act_cfg == $past(stage_q));
  // R5: locked strobe does nothing to the live words
  a_r5_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && upd_lock) |=> $stable(act_cfg));
  // R6: flag follows a write
  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend_flag);
  // R7: flag clears on a clean commit
  a_r7_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_strobe && !upd_lock && !wr_en) |=> !pend_flag);
  // R7: flag holds with neither write nor commit
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(upd_strobe && !upd_lock)) |=> $stable(pend_flag));
endmodule

bind dbuf_cfg_bank dbuf_cfg_bank_chk #(.FLAT_W(FLAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .upd_strobe(upd_strobe),
  .upd_lock(upd_lock), .stage_q(stage_q), .act_cfg(act_cfg), .pend_flag(pend_flag)
);

// File: tb/dbuf_cfg_bank_bench.sv
module dbuf_cfg_bank_bench;
  localparam int NR = 8;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [DW-1:0] SEED = 32'hA5A5_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic upd_strobe = 1'b0;
  logic upd_lock = 1'b0;
  logic [NR*DW-1:0] act_cfg;
  logic pend_flag;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_live [NR];
  logic [DW-1:0] exp_stage [NR];
  logic exp_pend;

  always #2 clk = ~clk;

  dbuf_cfg_bank u_dbuf_cfg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_strobe(upd_strobe), .upd_lock(upd_lock), .act_cfg(act_cfg), .pend_flag(pend_flag)
  );

  // one cycle with the given stimulus; model updated per the requirements
  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic st, input logic lk);
    wr_en = we; wr_addr = a; wr_data = d; upd_strobe = st; upd_lock = lk;
    @(posedge clk);
    #1;
    if (st && !lk) begin
      for (int i = 0; i < NR; i++) exp_live[i] = exp_stage[i];
      exp_pend = 1'b0;
    end
    if (we) begin
      exp_stage[a] = d;
      exp_pend = 1'b1;
    end
    wr_en = 1'b0; upd_strobe = 1'b0;
  endtask

  task automatic chk_live(input string tag);
    for (int i = 0; i < NR; i++) begin
      n_chk++;
      if (act_cfg[i*DW +: DW] !== exp_live[i]) begin
        n_bad++;
        $display("FAIL %s word %0d: got %h expected %h", tag, i, act_cfg[i*DW +: DW], exp_live[i]);
      end
    end
  endtask

  task automatic chk_flag(input string tag);
    n_chk++;
    if (pend_flag !== exp_pend) begin
      n_bad++;
      $display("FAIL %s pend_flag: got %b expected %b", tag, pend_flag, exp_pend);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < NR; i++) begin
      exp_live[i] = SEED ^ DW'(i);
      exp_stage[i] = SEED ^ DW'(i);
    end
    exp_pend = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_live("R1 reset");
    chk_flag("R1 reset");
  endtask

  task automatic t_hold_then_apply;
    cyc(1, 3'd2, 32'h1111_2222, 0, 0);
    chk_flag("R6 after write");
    chk_live("R2 write not live");
    cyc(0, 0, 0, 0, 0);
    chk_live("R2 idle");
    cyc(0, 0, 0, 1, 0);
    chk_live("R3 commit");
    chk_flag("R7 clear");
    chk_live("R9 untouched");
  endtask

  task automatic t_mailbox;
    cyc(1, 3'd5, 32'h0000_0001, 0, 0);
    cyc(1, 3'd5, 32'h0000_0002, 0, 0);
    cyc(1, 3'd5, 32'hCAFE_F00D, 0, 0);
    cyc(1, 3'd0, 32'hDEAD_0000, 0, 0);
    chk_live("R2 before strobe");
    cyc(0, 0, 0, 1, 0);
    chk_live("R4 last write wins");
    if (exp_live[5] !== 32'hCAFE_F00D) begin n_bad++; $display("FAIL R4 model %h expected %h", exp_live[5], 32'hCAFE_F00D); end
    n_chk++;
  endtask

  task automatic t_lock;
    cyc(1, 3'd7, 32'h7777_7777, 0, 1);
    cyc(0, 0, 0, 1, 1);
    chk_live("R5 locked strobe");
    chk_flag("R7 stays while locked");
    cyc(1, 3'd6, 32'h6666_6666, 0, 1);
    cyc(0, 0, 0, 1, 1);
    chk_live("R5 second locked strobe");
    cyc(0, 0, 0, 0, 0);
    chk_live("R5 lock released no strobe");
    cyc(0, 0, 0, 1, 0);
    chk_live("R5 deferred apply");
    chk_flag("R7 clear after release");
  endtask

  task automatic t_same_cycle;
    cyc(1, 3'd1, 32'h0101_0101, 0, 0);
    cyc(1, 3'd1, 32'h0202_0202, 1, 0);
    chk_live("R8 older value applied");
    chk_flag("R8 flag still set");
    cyc(0, 0, 0, 1, 0);
    chk_live("R8 newer value applied");
    chk_flag("R8 flag clear");
  endtask

  task automatic t_reset_again;
    cyc(1, 3'd4, 32'h4444_4444, 0, 0);
    t_reset();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_hold_then_apply();
        t_mailbox();
        t_lock();
        t_same_cycle();
        t_reset_again();
      end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule